// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write Protector

This block is the digital control core of a battery-backed SRAM supervisor. It sits between a host's four active-low chip-enable lines and up to four SRAM devices. While the supply is healthy, it decodes the host enables onto the device enables according to a bank-organization strap. When an external comparator flags a supply failure, the block stops any new access from starting. An access that is already running may continue for a bounded number of timer ticks. After that, every device enable is held inactive until the supply has been good again for a recovery interval.

The failure flag is asynchronous. It passes through a chain of synchronizer flops before it acts. All timing is counted in pulses of a clock-enable tick, so the windows can be scaled for simulation. The strap is captured each time the supply crosses back into tolerance. The block also drives the enable of the battery switch. That enable stays off until the supply has been applied at least once, so a battery fitted during manufacture is not drained in storage.

Top module: `sram_guard_top`

## Requirements
- R1: In the running phase with latched mode 00 (four banks of one device), `cen_o[k]` equals `cen_i[k]` for every k and every input pattern.
- R2: In the running phase with latched mode 01 (two banks of two devices), `cen_i[0]` enables bank 0 (outputs 0 and 1) and `cen_i[1]` enables bank 1 (outputs 2 and 3). `cen_i[2]` is address A: low selects the lower output of the bank, high selects the upper one. No other output goes low.
- R3: In the running phase with latched mode 10 (one bank of four devices), `cen_i[0]` is the bank enable and `{cen_i[3],cen_i[2]}` is the index of the single output driven low. Latched mode 11 behaves as mode 00.
- R4: An output whose decoded request is inactive at the moment failure takes effect stays high for the whole failed phase, even if its input goes low later.
- R5: An output whose request is active when failure takes effect stays low until that request drops. From then on it stays high, even if the request returns.
- R6: During a failed phase, all outputs are forced high at the WINDOW_TICKS-th tick after failure took effect, and not before.
- R7: After the failure flag clears, all outputs stay high for RECOVER_TICKS ticks whatever the inputs. After the last of those ticks, the normal decode resumes.
- R8: A failure flagged again during recovery returns the block to the failed phase with no access allowed.
- R9: The strap is latched only on the transition from failed to recovery. A strap change while the supply is good has no effect on the decode.
- R10: Once unsealed, `bkp_en_o` is high exactly when the synchronized failure flag is set and `below_bat_i` is high.
- R11: From reset until the first failed-to-recovery transition, `bkp_en_o` stays low whatever the other inputs.
- R12: After reset, the block starts in the failed phase: all outputs are high and `bkp_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock-enable pulse that advances both timers |
| pfail_i | input | 1 | Asynchronous flag, high while supply is below trip point |
| below_bat_i | input | 1 | High while supply is below battery voltage |
| strap_i | input | 2 | Bank-organization strap (00, 01, 10; 11 acts as 00) |
| cen_i | input | 4 | Active-low chip enables from host |
| cen_o | output | 4 | Active-low chip enables to the SRAM devices |
| bkp_en_o | output | 1 | Enable of the battery-to-rail switch |

## Verification
The bench builds the block with WINDOW_TICKS of 4, RECOVER_TICKS of 6 and two synchronizer stages. These short windows let it step both timers one tick at a time and check the outputs on each side of the last tick. All sixteen host enable patterns are swept under every strap setting, and the expected decode is computed arithmetically. The same small setup reaches the corner cases quickly: an access ending early versus one hitting the timeout, a failure during recovery, and the battery-switch seal before the first power-up.

// File: rtl/sram_guard_pkg.sv
package sram_guard_pkg;

   localparam int unsigned CE_COUNT = 4;

   typedef enum logic [1:0] {
      MD_QUAD   = 2'b00,
      MD_PAIR   = 2'b01,
      MD_SINGLE = 2'b10,
      MD_RSVD   = 2'b11
   } bank_mode_e;

   typedef enum logic [1:0] {
      PH_RUN     = 2'b00,
      PH_HOLD    = 2'b01,
      PH_RECOVER = 2'b10
   } guard_phase_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sg_flag_sync.sv
module sg_flag_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sg_flag_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sg_power_seq.sv
module sg_power_seq
   import sram_guard_pkg::*;
#(
   parameter int unsigned WINDOW_TICKS  = 75,
   parameter int unsigned RECOVER_TICKS = 6250
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         fail_i,
   input  logic [1:0]   strap_i,
   output guard_phase_e phase_o,
   output logic         enter_hold_o,
   output logic         expire_o,
   output bank_mode_e   mode_o,
   output logic         sealed_o
);

   if (WINDOW_TICKS < 1) begin : g_bad_window
      $error("sg_power_seq: WINDOW_TICKS must be at least 1");
   end
   if (RECOVER_TICKS < 1) begin : g_bad_recover
      $error("sg_power_seq: RECOVER_TICKS must be at least 1");
   end

   localparam int unsigned MAX_TICKS = max_of(WINDOW_TICKS, RECOVER_TICKS);
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(WINDOW_TICKS - 1);
   localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(RECOVER_TICKS - 1);

   guard_phase_e     phase_q;
   logic [CNT_W-1:0] cnt_q;
   bank_mode_e       mode_q;
   logic             sealed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q  <= PH_HOLD;
         cnt_q    <= '0;
         mode_q   <= MD_QUAD;
         sealed_q <= 1'b1;
      end else begin
         unique case (phase_q)
            PH_RUN: begin
               if (fail_i) begin
                  phase_q <= PH_HOLD;
                  cnt_q   <= '0;
               end
            end
            PH_HOLD: begin
               if (!fail_i) begin
                  phase_q  <= PH_RECOVER;
                  cnt_q    <= '0;
                  mode_q   <= bank_mode_e'(strap_i);
                  sealed_q <= 1'b0;
               end else if (tick_i && (cnt_q != HOLD_LAST)) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_RECOVER: begin
               if (fail_i) begin
                  phase_q <= PH_HOLD;
                  cnt_q   <= '0;
               end else if (tick_i) begin
                  if (cnt_q == REC_LAST) begin
                     phase_q <= PH_RUN;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               phase_q <= PH_HOLD;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign phase_o      = phase_q;
   assign enter_hold_o = (phase_q == PH_RUN) && fail_i;
   assign expire_o     = (phase_q == PH_HOLD) && tick_i && (cnt_q == HOLD_LAST);
   assign mode_o       = mode_q;
   assign sealed_o     = sealed_q;

   AST_SEAL_NEVER_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(sealed_q) |-> !sealed_q); // R11

   AST_RECOVER_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_RECOVER) |-> (cnt_q <= REC_LAST)); // R7

   AST_RUN_ONLY_FROM_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_RUN && $past(phase_q) != PH_RUN) |-> ($past(phase_q) == PH_RECOVER)); // R7

endmodule

// File: rtl/sg_bank_decode.sv
module sg_bank_decode
   import sram_guard_pkg::*;
(
   input  bank_mode_e          mode_i,
   input  logic [CE_COUNT-1:0] cen_i,
   output logic [CE_COUNT-1:0] req_o
);

   logic [CE_COUNT-1:0] act;
   logic                addr_a;
   logic [1:0]          sel;

   assign act    = ~cen_i;
   assign addr_a = cen_i[2];
   assign sel    = {cen_i[3], cen_i[2]};

   for (genvar k = 0; k < CE_COUNT; k++) begin : g_req
      localparam int unsigned BANK = k / 2;
      localparam bit          UPPER = (k % 2) == 1;
      always_comb begin
         unique case (mode_i)
            MD_PAIR:   req_o[k] = act[BANK] && (addr_a == UPPER);
            MD_SINGLE: req_o[k] = act[0] && (sel == 2'(k));
            default:   req_o[k] = act[k];
         endcase
      end
   end

endmodule

// File: rtl/sg_ce_gate.sv
module sg_ce_gate
   import sram_guard_pkg::*;
(
   input  logic                clk_i,
   input  logic                rst_ni,
   input  guard_phase_e        phase_i,
   input  logic                enter_hold_i,
   input  logic                expire_i,
   input  logic [CE_COUNT-1:0] req_i,
   output logic [CE_COUNT-1:0] cen_o
);

   logic [CE_COUNT-1:0] grant_q;
   logic [CE_COUNT-1:0] permit;

   for (genvar k = 0; k < CE_COUNT; k++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            grant_q[k] <= 1'b0;
         end else if (enter_hold_i) begin
            grant_q[k] <= req_i[k];
         end else if (phase_i == PH_HOLD) begin
            grant_q[k] <= grant_q[k] && req_i[k] && !expire_i;
         end else begin
            grant_q[k] <= 1'b0;
         end
      end

      always_comb begin
         unique case (phase_i)
            PH_RUN:  permit[k] = 1'b1;
            PH_HOLD: permit[k] = grant_q[k];
            default: permit[k] = 1'b0;
         endcase
      end

      assign cen_o[k] = !(req_i[k] && permit[k]);
   end

   AST_NO_NEW_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_i == PH_HOLD && $past(phase_i) == PH_HOLD) |-> ((grant_q & ~$past(grant_q)) == '0)); // R5

   AST_BLOCKED_STAYS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_i == PH_HOLD && $past(phase_i) == PH_HOLD) |-> ((~cen_o & ~$past(grant_q)) == '0)); // R4

   AST_TIMEOUT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_i == PH_HOLD && expire_i) |=> (grant_q == '0)); // R6

endmodule

// File: rtl/sram_guard_top.sv
module sram_guard_top
   import sram_guard_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned WINDOW_TICKS  = 75,
   parameter int unsigned RECOVER_TICKS = 6250
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       pfail_i,
   input  logic       below_bat_i,
   input  logic [1:0] strap_i,
   input  logic [3:0] cen_i,
   output logic [3:0] cen_o,
   output logic       bkp_en_o
);

   if (CE_COUNT != 4) begin : g_bad_count
      $error("sram_guard_top: the bank decode is built for four enables");
   end

   logic                fail_s;
   guard_phase_e        phase;
   logic                enter_hold;
   logic                expire;
   bank_mode_e          mode_q;
   logic                sealed;
   logic [CE_COUNT-1:0] req;

   sg_flag_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (pfail_i),
      .sync_o  (fail_s)
   );

   sg_power_seq #(
      .WINDOW_TICKS  (WINDOW_TICKS),
      .RECOVER_TICKS (RECOVER_TICKS)
   ) u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick_i),
      .fail_i       (fail_s),
      .strap_i      (strap_i),
      .phase_o      (phase),
      .enter_hold_o (enter_hold),
      .expire_o     (expire),
      .mode_o       (mode_q),
      .sealed_o     (sealed)
   );

   sg_bank_decode u_dec (
      .mode_i (mode_q),
      .cen_i  (cen_i),
      .req_o  (req)
   );

   sg_ce_gate u_gate (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .phase_i      (phase),
      .enter_hold_i (enter_hold),
      .expire_i     (expire),
      .req_i        (req),
      .cen_o        (cen_o)
   );

   assign bkp_en_o = !sealed && fail_s && below_bat_i;

   AST_RECOVER_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase == PH_RECOVER) |-> (cen_o == 4'hF)); // R7

   AST_SINGLE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MD_SINGLE) |-> $onehot0(~cen_o)); // R3

   AST_PAIR_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == MD_PAIR) |-> ($countones(~cen_o) <= 2)); // R2

   AST_BACKUP_SEALED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sealed |-> !bkp_en_o); // R11

   AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(mode_q) |-> (phase == PH_RECOVER && $past(phase) == PH_HOLD)); // R9

   AST_BACKUP_ONLY_FAILED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase == PH_RUN && !fail_s) |-> !bkp_en_o); // R10

endmodule

// File: tb/tb_sram_guard_top.sv
module tb_sram_guard_top;

   localparam int W_T = 4;
   localparam int R_T = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       pfail = 1'b1;
   logic       below = 1'b1;
   logic [1:0] strap = 2'b00;
   logic [3:0] cen = 4'hF;
   logic [3:0] cen_out;
   logic       bkp;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sram_guard_top #(
      .SYNC_STAGES   (2),
      .WINDOW_TICKS  (W_T),
      .RECOVER_TICKS (R_T)
   ) dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_i      (tick),
      .pfail_i     (pfail),
      .below_bat_i (below),
      .strap_i     (strap),
      .cen_i       (cen),
      .cen_o       (cen_out),
      .bkp_en_o    (bkp)
   );

   function automatic logic [3:0] exp_map(input logic [1:0] md, input logic [3:0] c);
      logic [3:0] act;
      logic [3:0] r;
      act = ~c;
      r   = 4'h0;
      case (md)
         2'b01: begin
            r[0] = act[0] & ~c[2];
            r[1] = act[0] &  c[2];
            r[2] = act[1] & ~c[2];
            r[3] = act[1] &  c[2];
         end
         2'b10: r = act[0] ? (4'b0001 << {c[3], c[2]}) : 4'h0;
         default: r = act;
      endcase
      return ~r;
   endfunction

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
      settle();
   endtask

   task automatic power_up(input logic [1:0] md);
      strap = md;
      pfail = 1'b0;
      settle();
      strap = ~md;           // later strap changes must not matter (R9)
      chk("R7 recovery start", cen_out, 4'hF);
      ticks(R_T - 1);
      chk("R7 before last tick", cen_out, 4'hF);
      ticks(1);
   endtask

   task automatic sweep(input string req, input logic [1:0] md);
      for (int v = 0; v < 16; v++) begin
         @(negedge clk) cen = 4'(v);
         @(negedge clk);
         chk(req, cen_out, exp_map(md, 4'(v)));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R12 / R11: reset state and seal
      chk("R12 outputs idle", cen_out, 4'hF);
      chk("R12 backup off", {3'b0, bkp}, 4'h0);
      cen = 4'h0;
      settle();
      chk("R11 sealed outputs high", cen_out, 4'hF);
      chk("R11 sealed backup off", {3'b0, bkp}, 4'h0);
      cen = 4'hF;

      // power up in mode 00, recovery checked inside with inputs active
      cen = 4'h0;
      power_up(2'b00);
      chk("R10 backup off while good", {3'b0, bkp}, 4'h0);
      sweep("R1 quad pass-through", 2'b00);
      strap = 2'b10;
      sweep("R9 strap ignored while running", 2'b00);

      // access in progress at failure, ended early
      cen = 4'b1010;
      settle();
      pfail = 1'b1;
      settle();
      chk("R5 held accesses stay low", cen_out, 4'b1010);
      chk("R10 backup on", {3'b0, bkp}, 4'h1);
      below = 1'b0;
      settle();
      chk("R10 backup off above battery", {3'b0, bkp}, 4'h0);
      below = 1'b1;
      cen = 4'b1000;
      settle();
      chk("R4 idle lane stays high", cen_out, 4'b1010);
      cen = 4'b1001;
      settle();
      chk("R5 lane 0 released", cen_out, 4'b1011);
      cen = 4'b1000;
      settle();
      chk("R5 lane 0 no re-grant", cen_out, 4'b1011);
      ticks(W_T - 1);
      chk("R6 before timeout", cen_out, 4'b1011);
      ticks(1);
      chk("R6 at timeout", cen_out, 4'hF);

      // recovery in mode 01, then failure during recovery
      power_up(2'b01);
      sweep("R2 pair decode", 2'b01);
      cen = 4'h0;
      pfail = 1'b1;
      settle();
      ticks(W_T);
      pfail = 1'b0;
      strap = 2'b10;
      settle();
      ticks(2);
      pfail = 1'b1;
      settle();
      chk("R8 refail blocks all", cen_out, 4'hF);
      ticks(W_T + 2);
      chk("R8 still blocked", cen_out, 4'hF);

      power_up(2'b10);
      sweep("R3 single decode", 2'b10);

      // access that runs into the timeout in mode 10
      cen = 4'b1100;         // enable low, select {1,1}
      settle();
      pfail = 1'b1;
      settle();
      chk("R5 single held", cen_out, 4'b0111);
      ticks(W_T - 1);
      chk("R6 single before timeout", cen_out, 4'b0111);
      ticks(1);
      chk("R6 single timeout", cen_out, 4'hF);

      power_up(2'b11);
      sweep("R3 reserved acts as quad", 2'b11);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired got=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule